// File: doc/BRIEF.md
# Sparsified Daisy-Chain Event Readout

This block sits at the output end of a front-end readout chip that is one link in a serial chain. When a stored event row is presented with a load strobe, it is captured into a shift register and sent out one bit per clock: first a two-bit event tag, then a hit flag, and then 64 channel bits. The channel bits are sent only when the hit flag is set. When the flag is clear, the block sends just the three header bits and then hands its output back to the serial stream arriving from the upstream chip. Chips with no hits therefore add almost nothing to the chain's data volume.

The stored row carries the header twice, once at each end, so that the same row can be read toward either end of the chain. A direction input, sampled at load time, picks which header copy is used and whether channels go out in ascending or descending order. An isolate input blocks the upstream stream so that a faulty neighbour cannot corrupt the chain. Whenever the block is not sending its own frame, the output forwards the (possibly blocked) upstream bit combinationally, so idle chips are transparent.

Top module: `rdo_sparse_chain`

## Requirements
- R1: After reset, and with no load yet, ser_o equals up_data_i when isolate_i is 0; no frame bits are sent.
- R2: On the first cycle after the load edge, ser_o carries tag bit 1, then tag bit 0, then the hit flag. With dir_right_i=0 these are row columns 0, 1 and 2; with dir_right_i=1 they are columns 69, 68 and 67.
- R3: With dir_right_i=0 at load and row column 2 set, the header is followed by channels 0 to 63 in ascending order, taken from row columns 3 to 66 (channel k at column k+3).
- R4: With dir_right_i=1 at load and row column 67 set, the header is followed by channels 63 down to 0, taken from row columns 66 down to 3.
- R5: When the selected hit flag is 0, exactly 3 bits are sent; from the fourth cycle ser_o forwards upstream data. The hit copy of the other direction has no effect.
- R6: When the hit flag is 1, exactly 67 bits are sent; from the 68th cycle ser_o forwards upstream data.
- R7: While isolate_i is 1 and no frame is being sent, ser_o is 0 whatever up_data_i is.
- R8: The direction is sampled at the load edge; changing dir_right_i during a frame does not alter that frame's bits.
- R9: A load strobe during a frame abandons the current frame and starts the new row's frame on the next cycle.
- R10: While the block's own frame is being sent, up_data_i and isolate_i do not affect ser_o.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| load_i | input | 1 | Load strobe: capture row_i and start a frame |
| row_i | input | 70 | Stored event row (left header, 64 channels, right header) |
| up_data_i | input | 1 | Serial data from the upstream chip |
| dir_right_i | input | 1 | 0 reads toward the left, 1 toward the right |
| isolate_i | input | 1 | 1 blocks upstream data |
| ser_o | output | 1 | Serial data toward the downstream chip |

## Verification
The hardest case from the ports is a row whose two hit copies disagree, combined with a direction flip or a new load arriving in the middle of a frame, because only then can the sampling point of the direction and the frame length be told apart. The stimulus builds rows with a set hit copy on one end and a clear one on the other, flips the direction inputs partway through a frame, and reloads after ten bits, while toggling the upstream line throughout so that any leak of pass-through into the frame shows up.

// File: rtl/rdo_pkg.sv
package rdo_pkg;

  typedef enum logic {
    DIR_LEFT  = 1'b0,
    DIR_RIGHT = 1'b1
  } rdo_dir_e;

  // Number of bits a frame occupies, given the sampled hit flag.
  function automatic int unsigned frame_bits(input logic hit,
                                             input int unsigned hdr_w,
                                             input int unsigned full_w);
    return hit ? full_w : hdr_w;
  endfunction

endpackage

// File: rtl/rdo_rst_sync.sv
module rdo_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);

  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= 2'b00;
    end else begin
      sync_q <= {sync_q[0], 1'b1};
    end
  end

  assign rst_n_sync = sync_q[1];

endmodule

// File: rtl/rdo_row_order.sv
module rdo_row_order #(
  parameter int unsigned HDR_W  = 3,
  parameter int unsigned NUM_CH = 64,
  localparam int unsigned ROW_W   = 2 * HDR_W + NUM_CH,
  localparam int unsigned FRAME_W = HDR_W + NUM_CH
) (
  input  logic [ROW_W-1:0]   row_i,
  input  logic               dir_right_i,
  output logic [FRAME_W-1:0] frame_o,
  output logic               hit_o
);

  logic [FRAME_W-1:0] left_v;
  logic [FRAME_W-1:0] right_v;

  // Bit FRAME_W-1 of each vector is the first to leave the chip.
  for (genvar i = 0; i < FRAME_W; i++) begin : g_order
    assign left_v[FRAME_W-1-i]  = row_i[i];
    assign right_v[FRAME_W-1-i] = row_i[ROW_W-1-i];
  end

  assign frame_o = (dir_right_i == rdo_pkg::DIR_RIGHT) ? right_v : left_v;
  assign hit_o   = frame_o[FRAME_W-HDR_W];

endmodule

// File: rtl/rdo_frame_counter.sv
module rdo_frame_counter #(
  parameter int unsigned HDR_W   = 3,
  parameter int unsigned FRAME_W = 67,
  localparam int unsigned CNT_W  = $clog2(FRAME_W + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load_i,
  input  logic             hit_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             busy_o
);

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_d;
  logic             cnt_en;

  assign busy_o = (cnt_q != '0);
  assign cnt_en = load_i | busy_o;

  always_comb begin
    cnt_d = cnt_q;
    if (load_i) begin
      cnt_d = CNT_W'(rdo_pkg::frame_bits(hit_i, HDR_W, FRAME_W));
    end else if (busy_o) begin
      cnt_d = cnt_q - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (cnt_en) begin
      cnt_q <= cnt_d;
    end
  end

  assign cnt_o = cnt_q;

endmodule

// File: rtl/rdo_frame_shifter.sv
module rdo_frame_shifter #(
  parameter int unsigned FRAME_W = 67
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               load_i,
  input  logic               busy_i,
  input  logic [FRAME_W-1:0] frame_i,
  output logic               head_o
);

  logic [FRAME_W-1:0] sr_q;
  logic [FRAME_W-1:0] sr_d;
  logic               sr_en;

  assign sr_en = load_i | busy_i;

  always_comb begin
    sr_d = sr_q;
    if (load_i) begin
      sr_d = frame_i;
    end else if (busy_i) begin
      sr_d = {sr_q[FRAME_W-2:0], 1'b0};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sr_q <= '0;
    end else if (sr_en) begin
      sr_q <= sr_d;
    end
  end

  assign head_o = sr_q[FRAME_W-1];

endmodule

// File: rtl/rdo_sparse_chain.sv
module rdo_sparse_chain #(
  parameter int unsigned TAG_W  = 2,
  parameter int unsigned NUM_CH = 64,
  localparam int unsigned HDR_W   = TAG_W + 1,
  localparam int unsigned FRAME_W = HDR_W + NUM_CH,
  localparam int unsigned ROW_W   = 2 * HDR_W + NUM_CH,
  localparam int unsigned CNT_W   = $clog2(FRAME_W + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load_i,
  input  logic [ROW_W-1:0] row_i,
  input  logic             up_data_i,
  input  logic             dir_right_i,
  input  logic             isolate_i,
  output logic             ser_o
);

  logic               rst_n_sync;
  logic [FRAME_W-1:0] frame;
  logic               hit_sel;
  logic [CNT_W-1:0]   cnt;
  logic               busy;
  logic               head_bit;
  logic               up_gated;

  rdo_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_n_sync)
  );

  rdo_row_order #(
    .HDR_W  (HDR_W),
    .NUM_CH (NUM_CH)
  ) u_order (
    .row_i       (row_i),
    .dir_right_i (dir_right_i),
    .frame_o     (frame),
    .hit_o       (hit_sel)
  );

  rdo_frame_counter #(
    .HDR_W   (HDR_W),
    .FRAME_W (FRAME_W)
  ) u_cnt (
    .clk    (clk),
    .rst_n  (rst_n_sync),
    .load_i (load_i),
    .hit_i  (hit_sel),
    .cnt_o  (cnt),
    .busy_o (busy)
  );

  rdo_frame_shifter #(
    .FRAME_W (FRAME_W)
  ) u_sr (
    .clk     (clk),
    .rst_n   (rst_n_sync),
    .load_i  (load_i),
    .busy_i  (busy),
    .frame_i (frame),
    .head_o  (head_bit)
  );

  assign up_gated = up_data_i & ~isolate_i;
  assign ser_o    = busy ? head_bit : up_gated;

endmodule

// File: rtl/rdo_sparse_chain_chk.sv
module rdo_sparse_chain_chk #(
  parameter int unsigned HDR_W   = 3,
  parameter int unsigned FRAME_W = 67,
  parameter int unsigned ROW_W   = 70,
  parameter int unsigned CNT_W   = 7
) (
  input logic             clk,
  input logic             rst_n,
  input logic             load_i,
  input logic [ROW_W-1:0] row_i,
  input logic             up_data_i,
  input logic             dir_right_i,
  input logic             isolate_i,
  input logic             ser_o,
  input logic [CNT_W-1:0] cnt
);

  logic sel_hit;
  assign sel_hit = dir_right_i ? row_i[ROW_W-HDR_W] : row_i[HDR_W-1];

  // R1, R7: idle output is the blocked-or-forwarded upstream bit
  a_r7_idle_forward: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt == '0) |-> (ser_o == (up_data_i & ~isolate_i)));

  // R2: first frame bit is tag bit 1 from the chosen end
  a_r2_tag_first: assert property (@(posedge clk) disable iff (!rst_n)
    load_i |=> (ser_o == $past(dir_right_i ? row_i[ROW_W-1] : row_i[0])));

  // R5: clear hit flag gives a header-only frame
  a_r5_short_frame: assert property (@(posedge clk) disable iff (!rst_n)
    (load_i && !sel_hit) |=> (cnt == CNT_W'(HDR_W)));

  // R6: set hit flag gives a full frame
  a_r6_full_frame: assert property (@(posedge clk) disable iff (!rst_n)
    (load_i && sel_hit) |=> (cnt == CNT_W'(FRAME_W)));

  // R9: without a reload the remaining length drops by one per cycle
  a_r9_countdown: assert property (@(posedge clk) disable iff (!rst_n)
    ((cnt != '0) && !load_i) |=> (cnt == $past(cnt) - 1'b1));

endmodule

bind rdo_sparse_chain rdo_sparse_chain_chk #(
  .HDR_W   (HDR_W),
  .FRAME_W (FRAME_W),
  .ROW_W   (ROW_W),
  .CNT_W   (CNT_W)
) u_chk (
  .clk         (clk),
  .rst_n       (rst_n_sync),
  .load_i      (load_i),
  .row_i       (row_i),
  .up_data_i   (up_data_i),
  .dir_right_i (dir_right_i),
  .isolate_i   (isolate_i),
  .ser_o       (ser_o),
  .cnt         (cnt)
);

// File: tb/rdo_sparse_chain_tb.sv
module rdo_sparse_chain_tb;

  localparam int ROW_W = 70;

  logic             clk;
  logic             rst_n;
  logic             load_i;
  logic [ROW_W-1:0] row_i;
  logic             up_data_i;
  logic             dir_right_i;
  logic             isolate_i;
  logic             ser_o;

  int n_cmp;
  int n_bad;
  bit done;

  rdo_sparse_chain u_dut (
    .clk         (clk),
    .rst_n       (rst_n),
    .load_i      (load_i),
    .row_i       (row_i),
    .up_data_i   (up_data_i),
    .dir_right_i (dir_right_i),
    .isolate_i   (isolate_i),
    .ser_o       (ser_o)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  task automatic check(input logic got, input logic exp, input string req, input string what);
    n_cmp++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s %s: got %b expected %b", req, what, got, exp);
    end
  endtask

  function automatic logic exp_bit(input logic [ROW_W-1:0] r, input logic dr, input int i);
    return dr ? r[ROW_W-1-i] : r[i];
  endfunction

  function automatic int exp_len(input logic [ROW_W-1:0] r, input logic dr);
    logic h;
    h = dr ? r[67] : r[2];
    return h ? 67 : 3;
  endfunction

  // Drive a load at a negedge; the frame is then checked bit by bit.
  task automatic start_load(input logic [ROW_W-1:0] r, input logic dr);
    load_i      = 1'b1;
    row_i       = r;
    dir_right_i = dr;
    @(negedge clk);
    load_i = 1'b0;
  endtask

  // Check n frame bits starting at the current negedge; upstream toggled (R10).
  task automatic check_bits(input logic [ROW_W-1:0] r, input logic dr, input int first,
                            input int n, input string req, input bit flip_dir);
    for (int i = first; i < first + n; i++) begin
      up_data_i = i[0];
      isolate_i = i[1];
      if (flip_dir) dir_right_i = ~dr;
      #1;
      check(ser_o, exp_bit(r, dr, i), req, $sformatf("bit %0d", i));
      @(negedge clk);
    end
    isolate_i = 1'b0;
  endtask

  task automatic check_forward(input string req);
    for (int k = 0; k < 4; k++) begin
      up_data_i = k[0];
      isolate_i = k[1];
      #1;
      check(ser_o, k[0] & ~k[1], req, $sformatf("forward up=%0d iso=%0d", k[0], k[1]));
      @(negedge clk);
    end
    isolate_i = 1'b0;
  endtask

  function automatic logic [ROW_W-1:0] mk_row(input logic [1:0] tag, input logic hl,
                                              input logic hr, input logic [63:0] ch);
    logic [ROW_W-1:0] r;
    r[0] = tag[1]; r[1] = tag[0]; r[2] = hl;
    r[69] = tag[1]; r[68] = tag[0]; r[67] = hr;
    for (int k = 0; k < 64; k++) r[k+3] = ch[k];
    return r;
  endfunction

  task automatic t_reset;
    check_forward("R1");
    up_data_i = 1'b1;
    #1;
    check(ser_o, 1'b1, "R1", "idle after reset");
    @(negedge clk);
  endtask

  task automatic t_left_hit;
    logic [ROW_W-1:0] r;
    r = mk_row(2'b10, 1'b1, 1'b0, 64'h8000_0000_0000_0003 ^ 64'h00F0_0A50_1234_0000);
    start_load(r, 1'b0);
    check_bits(r, 1'b0, 0, 3, "R2", 1'b0);
    check_bits(r, 1'b0, 3, 64, "R3", 1'b0);
    check_forward("R6");
  endtask

  task automatic t_right_hit;
    logic [ROW_W-1:0] r;
    r = mk_row(2'b01, 1'b0, 1'b1, 64'h0000_0000_0000_0001 ^ 64'h5A00_0000_C300_0000);
    start_load(r, 1'b1);
    check_bits(r, 1'b1, 0, 3, "R2", 1'b0);
    check_bits(r, 1'b1, 3, 64, "R4", 1'b0);
    check_forward("R6");
  endtask

  task automatic t_no_hit;
    logic [ROW_W-1:0] r;
    r = mk_row(2'b11, 1'b0, 1'b1, 64'hFFFF_FFFF_FFFF_FFFF);
    start_load(r, 1'b0);
    check_bits(r, 1'b0, 0, 3, "R5", 1'b0);
    check_forward("R5");
    r = mk_row(2'b10, 1'b1, 1'b0, 64'hFFFF_0000_FFFF_0000);
    start_load(r, 1'b1);
    check_bits(r, 1'b1, 0, 3, "R5", 1'b0);
    check_forward("R5");
  endtask

  task automatic t_isolate;
    isolate_i = 1'b1;
    for (int k = 0; k < 3; k++) begin
      up_data_i = 1'b1;
      #1;
      check(ser_o, 1'b0, "R7", "isolated idle");
      @(negedge clk);
    end
    isolate_i = 1'b0;
  endtask

  task automatic t_dir_flip;
    logic [ROW_W-1:0] r;
    r = mk_row(2'b10, 1'b1, 1'b0, 64'h0123_4567_89AB_CDEF);
    start_load(r, 1'b0);
    check_bits(r, 1'b0, 0, exp_len(r, 1'b0), "R8", 1'b1);
    dir_right_i = 1'b0;
    check_forward("R8");
  endtask

  task automatic t_reload;
    logic [ROW_W-1:0] a;
    logic [ROW_W-1:0] b;
    a = mk_row(2'b11, 1'b1, 1'b1, 64'hAAAA_AAAA_AAAA_AAAA);
    b = mk_row(2'b01, 1'b1, 1'b0, 64'h0F0F_0000_F0F0_1111);
    start_load(a, 1'b1);
    check_bits(a, 1'b1, 0, 10, "R9", 1'b0);
    start_load(b, 1'b0);
    check_bits(b, 1'b0, 0, exp_len(b, 1'b0), "R9", 1'b0);
    check_forward("R9");
  endtask

  task automatic t_frame_ignores_up;
    logic [ROW_W-1:0] r;
    r = mk_row(2'b00, 1'b1, 1'b1, 64'h0);
    start_load(r, 1'b1);
    check_bits(r, 1'b1, 0, 67, "R10", 1'b0);
    check_forward("R10");
  endtask

  initial begin
    #50000;
    if (!done) begin
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog: got hang expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    n_cmp = 0;
    n_bad = 0;
    done  = 1'b0;
    rst_n = 1'b0;
    load_i = 1'b0;
    row_i = '0;
    up_data_i = 1'b0;
    dir_right_i = 1'b0;
    isolate_i = 1'b0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    t_reset();
    t_left_hit();
    t_right_hit();
    t_no_hit();
    t_isolate();
    t_dir_flip();
    t_reload();
    t_frame_ignores_up();
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule